// File: doc/BRIEF.md
# Tamper Input Deglitch and Zeroize

This block guards a small secret store against tampering. It watches an active-high tamper line, rejects short glitches, and on a confirmed event erases the store and briefly cuts a switched supply. The line first passes through a two-flop synchronizer. A pulse is then measured in timebase ticks and compared against one confirmation threshold. That threshold sits between a reject bound (`REJECT_TICKS`) and an accept bound (`ACCEPT_TICKS`), so the result for a given length is always the same.

A confirmed event sets a sticky `tampered` flag and starts a fixed sequence. The sequence zeroes every key entry, one per clock, and then every vector entry, one per clock. After that, `supply_cut` is held high for `CUT_TICKS` ticks. The key bank and the vector bank are register files inside the block, with one write/read port for ordinary use.

Top module: `tamper_zeroize`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `supply_cut`, `tampered`, `key_wipe` and `vec_wipe` are low, and every store entry reads zero.
- R2: Ticks are counted only while the synchronized input stays high, and a low level clears the count. An event is confirmed on the tick that brings the count to CONFIRM = (REJECT_TICKS+ACCEPT_TICKS)/2, which is 6 by default. A pulse spanning fewer than REJECT_TICKS ticks never confirms, and lengths in between give the same outcome every time.
- R3: A pulse spanning ACCEPT_TICKS or more ticks always confirms.
- R4: A tamper input held low never starts the sequence, however many ticks arrive.
- R5: A confirmed event sets `tampered`, and only reset clears it.
- R6: After confirmation, `key_wipe` is high for exactly KEY_WORDS consecutive clocks, and each of those clocks zeroes one key entry. Afterwards every key entry reads zero.
- R7: `vec_wipe` follows directly for exactly VEC_WORDS clocks, and afterwards every vector entry reads zero.
- R8: `supply_cut` then stays high for exactly CUT_TICKS ticks. `busy` is high from the first wipe clock until `supply_cut` falls, and the strobes and `supply_cut` are never high while `busy` is low.
- R9: Tamper activity during the sequence is ignored. A level still high when the sequence ends does not retrigger until it has gone low and been qualified again.
- R10: With `st_we` high and `busy` low, `st_wdata` is written to entry `st_addr` of the bank given by `st_bank` (0 = key, 1 = vector, which keeps the low VEC_W bits). Writes are ignored while `busy` is high. `st_rdata` shows that bank and entry combinationally, with vector data zero-extended.
- R11: A pulse that does not confirm leaves the store contents and `tampered` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tamper_in | input | 1 | Raw active-high tamper line |
| tick | input | 1 | Timebase strobe, one clock wide |
| st_we | input | 1 | Store write enable |
| st_bank | input | 1 | Bank select, 0 key, 1 vector |
| st_addr | input | IDX_W | Entry index |
| st_wdata | input | KEY_W | Write data |
| st_rdata | output | KEY_W | Read data of selected entry |
| key_wipe | output | 1 | High on each key-clearing clock |
| vec_wipe | output | 1 | High on each vector-clearing clock |
| busy | output | 1 | Sequence in progress |
| supply_cut | output | 1 | Switched supply disable pulse |
| tampered | output | 1 | Sticky confirmed-tamper flag |

## Verification
The assertions assume that `tick` is a single-clock strobe and that reset is held for at least one edge. They also assume the confirm pulse can only come from a synchronized level. The stimulus respects all of this: it raises `tick` for one clock at a time, with two idle clocks between ticks. It holds the tamper line steady for three clocks before the first counted tick, and releases it well clear of any tick, so that every pulse spans an exact, known tick count.

// File: rtl/tz_pkg.sv
// Package: shared state type and helper for the tamper zeroize block.
package tz_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_KEYS = 2'd1,
        SEQ_VECS = 2'd2,
        SEQ_CUT  = 2'd3
    } seq_state_t;

    // Larger of two counts, used to size shared index counters.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tz_qualifier.sv
// Tamper qualifier: synchronizes the raw line and counts ticks while it is high.
// Fires one clock when the count reaches CONFIRM. The count saturates there,
// so a held level never fires twice. Assumes tick is a single-clock strobe.
module tz_qualifier #(
    parameter int CONFIRM = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tamper_in,
    input  logic tick,
    input  logic busy,
    output logic fire
);
    localparam int CW = $clog2(CONFIRM + 1);
    localparam logic [CW-1:0] C_TOP  = CW'(CONFIRM);
    localparam logic [CW-1:0] C_LAST = CW'(CONFIRM - 1);

    logic          sync_a, sync_b;
    logic [CW-1:0] cnt;

    // Two-flop synchronizer on the asynchronous tamper line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
        end else begin
            sync_a <= tamper_in;
            sync_b <= sync_a;
        end
    end

    // Tick counter of the current high level; saturates while busy or at CONFIRM.
    always_ff @(posedge clk) begin
        if (!rst_n || !sync_b) begin
            cnt <= '0;
        end else if (busy) begin
            cnt <= C_TOP;
        end else if (tick && cnt != C_TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Confirmation on the tick that completes the count.
    always_comb begin
        fire = sync_b && tick && !busy && (cnt == C_LAST);
    end

endmodule

// File: rtl/tz_regfile.sv
// Register file standing in for a secret store. Clears are given priority over writes.
// The read is combinational and reset zeroes every entry.
module tz_regfile #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [W-1:0]             wdata,
    input  logic                     clr,
    input  logic [$clog2(DEPTH)-1:0] clr_addr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem [DEPTH];

    // Storage update: reset, wipe of one entry, or ordinary write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (clr) begin
            mem[clr_addr] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Combinational read of the addressed entry.
    always_comb begin
        rdata = mem[addr];
    end

endmodule

// File: rtl/tz_sequencer.sv
// Zeroize sequencer: walks the key bank, then the vector bank, one entry per clock.
// It then holds the supply disable for CUT_TICKS ticks. Assumes fire is a one-clock pulse.
module tz_sequencer
    import tz_pkg::*;
#(
    parameter int KEY_WORDS = 8,
    parameter int VEC_WORDS = 16,
    parameter int CUT_TICKS = 5,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             tick,
    output logic [IDX_W-1:0] wipe_idx,
    output logic             key_wipe,
    output logic             vec_wipe,
    output logic             supply_cut,
    output logic             busy
);
    localparam int TW = $clog2(CUT_TICKS + 1);
    localparam logic [IDX_W-1:0] K_LAST = IDX_W'(KEY_WORDS - 1);
    localparam logic [IDX_W-1:0] V_LAST = IDX_W'(VEC_WORDS - 1);
    localparam logic [TW-1:0]    T_LAST = TW'(CUT_TICKS - 1);

    seq_state_t    state;
    logic [TW-1:0] tcnt;

    // State, entry index and cut-tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            wipe_idx <= '0;
            tcnt     <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (fire) begin
                    state    <= SEQ_KEYS;
                    wipe_idx <= '0;
                end
                SEQ_KEYS: if (wipe_idx == K_LAST) begin
                    state    <= SEQ_VECS;
                    wipe_idx <= '0;
                end else begin
                    wipe_idx <= wipe_idx + 1'b1;
                end
                SEQ_VECS: if (wipe_idx == V_LAST) begin
                    state    <= SEQ_CUT;
                    wipe_idx <= '0;
                    tcnt     <= '0;
                end else begin
                    wipe_idx <= wipe_idx + 1'b1;
                end
                SEQ_CUT: if (tick) begin
                    if (tcnt == T_LAST) state <= SEQ_IDLE;
                    else                tcnt  <= tcnt + 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Output decode of the current state.
    always_comb begin
        key_wipe   = (state == SEQ_KEYS);
        vec_wipe   = (state == SEQ_VECS);
        supply_cut = (state == SEQ_CUT);
        busy       = (state != SEQ_IDLE);
    end

endmodule

// File: rtl/tamper_zeroize.sv
// Top: tamper qualifier, zeroize sequencer and the two secret banks.
// Assumes KEY_W >= VEC_W and REJECT_TICKS >= 1.
// The confirm threshold is the midpoint of the reject and accept bounds.
module tamper_zeroize
    import tz_pkg::*;
#(
    parameter int KEY_WORDS    = 8,
    parameter int KEY_W        = 32,
    parameter int VEC_WORDS    = 16,
    parameter int VEC_W        = 8,
    parameter int REJECT_TICKS = 4,
    parameter int ACCEPT_TICKS = 8,
    parameter int CUT_TICKS    = 5,
    localparam int IDX_W       = $clog2(max2(KEY_WORDS, VEC_WORDS))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tamper_in,
    input  logic             tick,
    input  logic             st_we,
    input  logic             st_bank,
    input  logic [IDX_W-1:0] st_addr,
    input  logic [KEY_W-1:0] st_wdata,
    output logic [KEY_W-1:0] st_rdata,
    output logic             key_wipe,
    output logic             vec_wipe,
    output logic             busy,
    output logic             supply_cut,
    output logic             tampered
);
    localparam int CONFIRM = (REJECT_TICKS + ACCEPT_TICKS) / 2;
    localparam int KAW     = $clog2(KEY_WORDS);
    localparam int VAW     = $clog2(VEC_WORDS);

    logic             confirm;
    logic [IDX_W-1:0] wipe_idx;
    logic [KEY_W-1:0] key_rd;
    logic [VEC_W-1:0] vec_rd;
    logic             key_we, vec_we;

    tz_qualifier #(.CONFIRM(CONFIRM)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .tamper_in (tamper_in),
        .tick      (tick),
        .busy      (busy),
        .fire      (confirm)
    );

    tz_sequencer #(
        .KEY_WORDS (KEY_WORDS),
        .VEC_WORDS (VEC_WORDS),
        .CUT_TICKS (CUT_TICKS),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (confirm),
        .tick       (tick),
        .wipe_idx   (wipe_idx),
        .key_wipe   (key_wipe),
        .vec_wipe   (vec_wipe),
        .supply_cut (supply_cut),
        .busy       (busy)
    );

    // Ordinary writes are blocked for the whole sequence.
    always_comb begin
        key_we = st_we && !st_bank && !busy;
        vec_we = st_we &&  st_bank && !busy;
    end

    tz_regfile #(.DEPTH(KEY_WORDS), .W(KEY_W)) u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (key_we),
        .addr     (st_addr[KAW-1:0]),
        .wdata    (st_wdata),
        .clr      (key_wipe),
        .clr_addr (wipe_idx[KAW-1:0]),
        .rdata    (key_rd)
    );

    tz_regfile #(.DEPTH(VEC_WORDS), .W(VEC_W)) u_vecs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (vec_we),
        .addr     (st_addr[VAW-1:0]),
        .wdata    (st_wdata[VEC_W-1:0]),
        .clr      (vec_wipe),
        .clr_addr (wipe_idx[VAW-1:0]),
        .rdata    (vec_rd)
    );

    // Read mux over the two banks.
    always_comb begin
        st_rdata = st_bank ? KEY_W'(vec_rd) : key_rd;
    end

    // Sticky tamper flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       tampered <= 1'b0;
        else if (confirm) tampered <= 1'b1;
    end

endmodule

// File: rtl/tz_checker.sv
// Checker: temporal properties of the tamper zeroize outputs, bound to the top.
module tz_checker (
    input logic clk,
    input logic rst_n,
    input logic confirm,
    input logic key_wipe,
    input logic vec_wipe,
    input logic supply_cut,
    input logic busy,
    input logic tampered
);
    // R8: nothing is driven while idle
    assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(key_wipe || vec_wipe || supply_cut));
    // R8: at most one phase at a time
    assert_one_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({key_wipe, vec_wipe, supply_cut}));
    // R5: tamper flag is sticky
    assert_sticky_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tampered |=> tampered);
    // R5: the sequence only starts on a confirmed event
    assert_busy_after_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> tampered);
    // R6: a confirm leads straight into the key wipe
    assert_confirm_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        confirm |=> key_wipe);
    // R7: the key wipe is followed by the key wipe or the vector wipe
    assert_key_then_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        key_wipe |=> (key_wipe || vec_wipe));
    // R8: busy ends with the supply pulse
    assert_cut_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_cut) |-> !busy);
    // R9: no confirm while a sequence runs
    assert_no_refire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !confirm);
endmodule

bind tamper_zeroize tz_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .confirm    (confirm),
    .key_wipe   (key_wipe),
    .vec_wipe   (vec_wipe),
    .supply_cut (supply_cut),
    .busy       (busy),
    .tampered   (tampered)
);

// File: tb/tb_tamper_zeroize.sv
module tb_tamper_zeroize;
    localparam int KW = 8, KWID = 32, VW = 16, VWID = 8;
    localparam int REJ = 4, ACC = 8, CUT = 5, IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0, tamper_in = 1'b0, tick = 1'b0;
    logic st_we = 1'b0, st_bank = 1'b0;
    logic [IW-1:0] st_addr = '0;
    logic [KWID-1:0] st_wdata = '0;
    logic [KWID-1:0] st_rdata;
    logic key_wipe, vec_wipe, busy, supply_cut, tampered;

    int checks = 0, errors = 0;
    int kc = 0, vc = 0, ct = 0;
    logic clr_mon = 1'b0;
    logic [KWID-1:0] ksh [KW];
    logic [KWID-1:0] vsh [VW];

    always #4 clk = ~clk;

    tamper_zeroize dut (
        .clk(clk), .rst_n(rst_n), .tamper_in(tamper_in), .tick(tick),
        .st_we(st_we), .st_bank(st_bank), .st_addr(st_addr), .st_wdata(st_wdata),
        .st_rdata(st_rdata), .key_wipe(key_wipe), .vec_wipe(vec_wipe),
        .busy(busy), .supply_cut(supply_cut), .tampered(tampered)
    );

    // Count wipe clocks and cut ticks, sampled at the active edge.
    always @(posedge clk) begin
        if (clr_mon) begin
            kc <= 0; vc <= 0; ct <= 0;
        end else begin
            if (key_wipe) kc <= kc + 1;
            if (vec_wipe) vc <= vc + 1;
            if (supply_cut && tick) ct <= ct + 1;
        end
    end

    function automatic bit exp_confirm(input int k);
        return k >= (REJ + ACC) / 2;
    endfunction

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tamper_in = 1'b0; tick = 1'b0; st_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic clear_mon();
        clr_mon = 1'b1;
        @(negedge clk);
        clr_mon = 1'b0;
    endtask

    task automatic wr(input bit bank, input int addr, input logic [KWID-1:0] d);
        st_we = 1'b1; st_bank = bank; st_addr = IW'(addr); st_wdata = d;
        @(negedge clk);
        st_we = 1'b0;
    endtask

    task automatic rd(input bit bank, input int addr, output logic [KWID-1:0] d);
        st_bank = bank; st_addr = IW'(addr);
        #1 d = st_rdata;
    endtask

    task automatic tick_once();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse(input int k);
        tamper_in = 1'b1;
        repeat (3) @(negedge clk);
        repeat (k) tick_once();
        tamper_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_idle();
        int guard = 0;
        while (busy && guard < 500) begin
            tick_once();
            guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic fill_random();
        for (int i = 0; i < KW; i++) begin
            ksh[i] = $urandom;
            wr(1'b0, i, ksh[i]);
        end
        for (int i = 0; i < VW; i++) begin
            vsh[i] = KWID'($urandom % 256);
            wr(1'b1, i, vsh[i]);
        end
    endtask

    task automatic check_zeroed(input string req_k, input string req_v);
        logic [KWID-1:0] d;
        int bad_k = 0, bad_v = 0;
        for (int i = 0; i < KW; i++) begin rd(1'b0, i, d); if (d != 0) bad_k++; end
        for (int i = 0; i < VW; i++) begin rd(1'b1, i, d); if (d != 0) bad_v++; end
        chk(bad_k == 0, req_k, bad_k, 0);
        chk(bad_v == 0, req_v, bad_v, 0);
    endtask

    task automatic check_intact(input string req);
        logic [KWID-1:0] d;
        int bad = 0;
        for (int i = 0; i < KW; i++) begin rd(1'b0, i, d); if (d != ksh[i]) bad++; end
        for (int i = 0; i < VW; i++) begin rd(1'b1, i, d); if (d != vsh[i]) bad++; end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic check_sequence_counts();
        chk(kc == KW, "R6 key wipe clocks", kc, KW);
        chk(vc == VW, "R7 vector wipe clocks", vc, VW);
        chk(ct == CUT, "R8 supply cut ticks", ct, CUT);
        chk(!busy && !supply_cut, "R8 busy ends with cut", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        logic [KWID-1:0] d;
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();

        // R1: reset state
        chk({busy, supply_cut, tampered, key_wipe, vec_wipe} == 5'b0, "R1 outputs", {busy, supply_cut, tampered, key_wipe, vec_wipe}, 0);
        rd(1'b0, KW - 1, d); chk(d == 0, "R1 key entry", d, 0);
        rd(1'b1, VW - 1, d); chk(d == 0, "R1 vector entry", d, 0);

        // R10: write and read back both banks, vector truncated to its width
        wr(1'b0, 3, 32'hCAFE_F00D);
        wr(1'b1, 5, 32'h1234_56A7);
        rd(1'b0, 3, d); chk(d == 32'hCAFE_F00D, "R10 key readback", d, 32'hCAFE_F00D);
        rd(1'b1, 5, d); chk(d == 32'h0000_00A7, "R10 vector readback", d, 32'h0000_00A7);

        // R4: input low with many ticks does nothing
        repeat (20) tick_once();
        chk(!tampered && !busy, "R4 idle line", tampered, 0);

        // R2/R11: short pulses below reject and between the bounds
        fill_random();
        pulse(REJ - 1);
        chk(!tampered, "R2 below reject", tampered, 0);
        pulse(5);
        chk(tampered == exp_confirm(5), "R2 between bounds", tampered, exp_confirm(5));
        pulse(5);
        chk(tampered == exp_confirm(5), "R2 repeatable", tampered, exp_confirm(5));
        check_intact("R11 store kept");

        // R3/R5/R6/R7/R8: pulse at the accept bound
        clear_mon();
        pulse(ACC);
        chk(tampered, "R3 accept confirms", tampered, 1);
        run_idle();
        check_sequence_counts();
        check_zeroed("R6 keys zero", "R7 vectors zero");
        chk(tampered, "R5 flag sticky", tampered, 1);

        // R10: a write during the sequence is ignored
        do_reset();
        fill_random();
        clear_mon();
        pulse(6);
        while (!vec_wipe) @(negedge clk);
        wr(1'b0, 0, 32'hDEAD_BEEF);
        run_idle();
        rd(1'b0, 0, d); chk(d == 0, "R10 write blocked while busy", d, 0);

        // R9: a level held through the sequence does not retrigger
        do_reset();
        clear_mon();
        pulse(6);
        tamper_in = 1'b1;
        run_idle();
        clear_mon();
        repeat (12) tick_once();
        chk(!busy && kc == 0, "R9 held level ignored", kc, 0);
        tamper_in = 1'b0;
        repeat (4) @(negedge clk);
        pulse(6);
        chk(busy || kc > 0, "R9 retrigger after release", kc, KW);
        run_idle();

        // R5: only reset clears the flag
        do_reset();
        chk(!tampered, "R5 reset clears flag", tampered, 0);

        // Random pulse lengths against the expected outcome
        for (int t = 0; t < 10; t++) begin
            int k;
            k = int'($urandom % 13);
            do_reset();
            fill_random();
            clear_mon();
            pulse(k);
            chk(tampered == exp_confirm(k), "R2 R3 random length", tampered, exp_confirm(k));
            if (exp_confirm(k)) begin
                run_idle();
                check_sequence_counts();
                check_zeroed("R6 random keys", "R7 random vectors");
            end else begin
                check_intact("R11 random kept");
            end
        end

        summary();
    end
endmodule